// File: doc/BRIEF.md
# Per-ID Read Tag Allocator

This block sits on the request path of a bridge that carries AXI4 read-address traffic into a split-transaction fabric. For each read-address request it picks a fabric source tag. The tag is built from the request's AXI ID and a per-ID slot counter, so every outstanding fabric request carries a tag that no other outstanding request has.

Fabric responses may come back in any order. A per-ID counter that simply wraps could therefore land on a slot whose earlier request is still in flight. To prevent this, the block keeps a busy flag for every tag. A flag is set when its request enters the fabric and cleared when the matching response is retired. While the tag chosen for the requesting ID is still busy, the request is held off with valid/ready backpressure.

The data path is a pass-through of the two handshakes: the fabric request is offered in the same cycle as the AXI request, and the AXI side is accepted in the cycle the fabric accepts. The retire strobe carries the full tag of the completed request.

Top module: `rtal_top`

## Requirements
- R1: With MAX_FLIGHT > 1, the offered tag is {ar_id, low log2(MAX_FLIGHT) bits of that ID's slot counter, 1'b0}. With the defaults (4 IDs, 2 slots) this is {id[1:0], slot, 0}, so ID 0 slot 1 is tag 2 and ID 1 slot 0 is tag 4.
- R2: The slot counter of an ID advances by one, modulo MAX_FLIGHT, only in a cycle where ar_valid and ar_ready are both high for that ID. A cycle with ar_valid low, or with req_ready low, leaves the counter unchanged.
- R3: While the candidate tag for ar_id is busy, ar_ready and req_valid are both low. No tag is ever issued twice while outstanding.
- R4: A retire with ret_valid high frees its tag. Retiring a different slot of the same ID, for example out of order, leaves the candidate stalled.
- R5: If a retire and a new allocation hit the same tag in the same cycle, the request is accepted in that cycle, and the tag stays busy afterwards.
- R6: A retire whose tag has bit 0 set (a write tag) has no effect on any busy flag.
- R7: Reset clears every slot counter and every busy flag. During reset the outputs already show that cleared state.
- R8: With MAX_FLIGHT = 1 the tag is {ar_id, 1'b0}, and each ID has at most one request outstanding.
- R9: req_valid = ar_valid AND candidate free, and ar_ready = req_ready AND candidate free. req_tag always shows the candidate tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ar_valid | input | 1 | AXI read-address valid |
| ar_ready | output | 1 | AXI read-address ready |
| ar_id | input | ID_W | AXI ID of the request |
| req_valid | output | 1 | Fabric request valid |
| req_ready | input | 1 | Fabric request ready |
| req_tag | output | TAG_W | Fabric source tag of the request |
| ret_valid | input | 1 | Response-retire strobe |
| ret_tag | input | TAG_W | Tag of the retired response |

## Verification
The main function is driven by a single ordered vector sequence in which one ID fills both of its slots and is then released out of order. This separates correct busy tracking from a counter that blindly wraps. A retire on the candidate tag in the same cycle as an allocation distinguishes a busy flag cleared before it is set from one dropped or left stuck. Cycles with fabric backpressure, with ar_valid low, and with a write-tag retire each show whether the counter and busy state are held apart from those events. Reset during activity, and a second instance with one slot per ID, cover the cleared state and the tag form without slot bits.

// File: rtl/rtal_pkg.sv
package rtal_pkg;
  function automatic int clog2_min1(input int v);
    return ($clog2(v) < 1) ? 1 : $clog2(v);
  endfunction
endpackage

// File: rtl/rtal_slot_bank.sv
module rtal_slot_bank #(
  parameter int NUM_IDS = 4,
  parameter int ID_W    = 2,
  parameter int SLOT_W  = 1,
  localparam int SLOT_WS = (SLOT_W < 1) ? 1 : SLOT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               adv,
  input  logic [ID_W-1:0]    sel_id,
  output logic [SLOT_WS-1:0] slot
);
  generate
    if (SLOT_W == 0) begin : g_noslot
      assign slot = '0;
    end else begin : g_slots
      logic [SLOT_W-1:0] cnt_q [NUM_IDS];
      logic [SLOT_W-1:0] cnt_d [NUM_IDS];
      for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        logic hit;
        assign hit = adv && (sel_id == ID_W'(i));
        always_comb begin
          cnt_d[i] = cnt_q[i];
          if (hit) cnt_d[i] = cnt_q[i] + 1'b1;
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)   cnt_q[i] <= '0;
          else if (hit) cnt_q[i] <= cnt_d[i];
        end
      end
      assign slot = cnt_q[sel_id];
    end
  endgenerate
endmodule

// File: rtl/rtal_busy_table.sv
module rtal_busy_table #(
  parameter int IDX_W = 3,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic [IDX_W-1:0] q_idx,
  output logic             q_busy
);
  logic [ENTRIES-1:0] busy_q, busy_d;

  // clear first, then set: a same-cycle hit ends up busy
  always_comb begin
    busy_d = busy_q;
    if (clr_en) busy_d[clr_idx] = 1'b0;
    if (set_en) busy_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy_q <= '0;
    else if (set_en || clr_en) busy_q <= busy_d;
  end

  // a retire arriving now already frees the queried entry
  assign q_busy = busy_q[q_idx] && !(clr_en && (clr_idx == q_idx));
endmodule

// File: rtl/rtal_top.sv
module rtal_top
  import rtal_pkg::*;
#(
  parameter int NUM_IDS    = 4,
  parameter int MAX_FLIGHT = 2,
  localparam int ID_W    = clog2_min1(NUM_IDS),
  localparam int SLOT_W  = $clog2(MAX_FLIGHT),
  localparam int SLOT_WS = (SLOT_W < 1) ? 1 : SLOT_W,
  localparam int IDX_W   = ID_W + SLOT_W,
  localparam int TAG_W   = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ar_valid,
  output logic             ar_ready,
  input  logic [ID_W-1:0]  ar_id,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [TAG_W-1:0] req_tag,
  input  logic             ret_valid,
  input  logic [TAG_W-1:0] ret_tag
);
  logic [SLOT_WS-1:0] slot;
  logic [IDX_W-1:0]   cand_idx;
  logic               cand_busy;
  logic               fire;
  logic               ret_ok;

  generate
    if (SLOT_W == 0) begin : g_idx_id
      assign cand_idx = ar_id;
    end else begin : g_idx_slot
      assign cand_idx = {ar_id, slot[SLOT_W-1:0]};
    end
  endgenerate

  assign req_tag   = {cand_idx, 1'b0};
  assign req_valid = ar_valid && !cand_busy;
  assign ar_ready  = req_ready && !cand_busy;
  assign fire      = ar_valid && ar_ready;
  assign ret_ok    = ret_valid && !ret_tag[0];

  rtal_slot_bank #(.NUM_IDS(NUM_IDS), .ID_W(ID_W), .SLOT_W(SLOT_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .adv(fire), .sel_id(ar_id), .slot(slot)
  );

  rtal_busy_table #(.IDX_W(IDX_W)) u_busy (
    .clk(clk), .rst_n(rst_n),
    .set_en(fire), .set_idx(cand_idx),
    .clr_en(ret_ok), .clr_idx(ret_tag[TAG_W-1:1]),
    .q_idx(cand_idx), .q_busy(cand_busy)
  );
endmodule

// File: rtl/rtal_chk.sv
module rtal_chk #(
  parameter int ID_W  = 2,
  parameter int TAG_W = 4,
  localparam int IDX_W = TAG_W - 1,
  localparam int ENTRIES = 1 << IDX_W
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ar_valid,
  input logic             ar_ready,
  input logic [ID_W-1:0]  ar_id,
  input logic             req_valid,
  input logic             req_ready,
  input logic [TAG_W-1:0] req_tag,
  input logic             ret_valid,
  input logic [TAG_W-1:0] ret_tag
);
  logic [ENTRIES-1:0] outs_q;
  logic fire, ret_ok;
  assign fire   = ar_valid && ar_ready;
  assign ret_ok = ret_valid && !ret_tag[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outs_q <= '0;
    else begin
      if (ret_ok) outs_q[ret_tag[TAG_W-1:1]] <= 1'b0;
      if (fire)   outs_q[req_tag[TAG_W-1:1]] <= 1'b1;
    end
  end

  assert_tag_form_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (!req_tag[0] && req_tag[TAG_W-1 -: ID_W] == ar_id));

  assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (!outs_q[req_tag[TAG_W-1:1]] ||
              (ret_ok && ret_tag[TAG_W-1:1] == req_tag[TAG_W-1:1])));

  assert_hold_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire ##1 $stable(ar_id)) |-> $stable(req_tag));

  assert_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (req_valid && req_ready));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ar_valid && req_ready && !ar_ready) |-> !req_valid);
endmodule

bind rtal_top rtal_chk #(.ID_W(ID_W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
  .ar_id(ar_id), .req_valid(req_valid), .req_ready(req_ready),
  .req_tag(req_tag), .ret_valid(ret_valid), .ret_tag(ret_tag)
);

// File: tb/rtal_top_tb.sv
module rtal_top_tb;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic       ar_valid, ar_ready, req_valid, req_ready, ret_valid;
  logic [1:0] ar_id;
  logic [3:0] req_tag, ret_tag;

  rtal_top #(.NUM_IDS(4), .MAX_FLIGHT(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ar_valid(ar_valid), .ar_ready(ar_ready),
    .ar_id(ar_id), .req_valid(req_valid), .req_ready(req_ready),
    .req_tag(req_tag), .ret_valid(ret_valid), .ret_tag(ret_tag)
  );

  logic       m_ar_valid, m_ar_ready, m_req_valid, m_ret_valid;
  logic [1:0] m_ar_id;
  logic [2:0] m_req_tag, m_ret_tag;

  rtal_top #(.NUM_IDS(4), .MAX_FLIGHT(1)) u_dut_m1 (
    .clk(clk), .rst_n(rst_n), .ar_valid(m_ar_valid), .ar_ready(m_ar_ready),
    .ar_id(m_ar_id), .req_valid(m_req_valid), .req_ready(1'b1),
    .req_tag(m_req_tag), .ret_valid(m_ret_valid), .ret_tag(m_ret_tag)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic outs(input string rq, input logic e_rdy, input logic e_rv, input logic [3:0] e_tag);
    chk(ar_ready === e_rdy, {rq, " ar_ready"}, int'(ar_ready), int'(e_rdy));
    chk(req_valid === e_rv, {rq, " req_valid"}, int'(req_valid), int'(e_rv));
    chk(req_tag === e_tag, {rq, " req_tag"}, int'(req_tag), int'(e_tag));
  endtask

  typedef struct packed {
    logic       arv;
    logic [1:0] id;
    logic       rr;
    logic       retv;
    logic [3:0] rtag;
    logic       e_rdy;
    logic       e_rv;
    logic [3:0] e_tag;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd0 },  // R1 id0 slot0
    '{1'b1, 2'd0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd2 },  // R1 id0 slot1
    '{1'b1, 2'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0 },  // R3 wrap onto busy tag
    '{1'b1, 2'd0, 1'b1, 1'b1, 4'd2, 1'b0, 1'b0, 4'd0 },  // R4 out-of-order retire
    '{1'b1, 2'd0, 1'b1, 1'b1, 4'd0, 1'b1, 1'b1, 4'd0 },  // R5 retire+alloc same tag
    '{1'b1, 2'd0, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd2 },  // R4 freed slot reused
    '{1'b1, 2'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0 },  // R5 tag 0 still busy
    '{1'b1, 2'd1, 1'b0, 1'b0, 4'd0, 1'b0, 1'b1, 4'd4 },  // R9 fabric backpressure
    '{1'b1, 2'd1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd4 },  // R2 no advance before
    '{1'b1, 2'd3, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd12},  // R1 id3
    '{1'b0, 2'd1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b0, 4'd6 },  // R9 no valid
    '{1'b0, 2'd0, 1'b1, 1'b1, 4'd1, 1'b0, 1'b0, 4'd0 },  // R6 write-tag retire
    '{1'b1, 2'd0, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd0 },  // R6 tag 0 still busy
    '{1'b1, 2'd1, 1'b1, 1'b0, 4'd0, 1'b1, 1'b1, 4'd6 },  // R2 idle cycle held
    '{1'b1, 2'd1, 1'b1, 1'b0, 4'd0, 1'b0, 1'b0, 4'd4 }   // R3 id1 full
  };

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    ar_valid = 1'b1; ar_id = 2'd2; req_ready = 1'b1; ret_valid = 1'b0; ret_tag = '0;
    m_ar_valid = 1'b0; m_ar_id = 2'd0; m_ret_valid = 1'b0; m_ret_tag = '0;
    #20;
    outs("R7 reset state", 1'b1, 1'b1, 4'd8);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ar_valid = VEC[i].arv; ar_id = VEC[i].id; req_ready = VEC[i].rr;
      ret_valid = VEC[i].retv; ret_tag = VEC[i].rtag;
      #1;
      outs($sformatf("vector %0d (R1 R2 R3 R4 R5 R6 R9)", i),
           VEC[i].e_rdy, VEC[i].e_rv, VEC[i].e_tag);
    end

    // R7: reset mid-run clears busy tag 0 and id3's counter
    @(negedge clk); ar_valid = 1'b0; ret_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    ar_valid = 1'b1; ar_id = 2'd0; req_ready = 1'b0; #1;
    outs("R7 busy cleared", 1'b0, 1'b1, 4'd0);
    ar_id = 2'd3; #1;
    outs("R7 counter cleared", 1'b0, 1'b1, 4'd12);
    ar_valid = 1'b0; req_ready = 1'b1;

    // R8: one slot per ID, tag {id,0}
    @(negedge clk); m_ar_valid = 1'b1; m_ar_id = 2'd2; #1;
    chk(m_ar_ready === 1'b1, "R8 accept", int'(m_ar_ready), 1);
    chk(m_req_tag === 3'd4, "R8 tag", int'(m_req_tag), 4);
    @(negedge clk); #1;
    chk(m_ar_ready === 1'b0 && m_req_valid === 1'b0, "R8 second stalls", int'(m_ar_ready), 0);
    @(negedge clk); m_ar_valid = 1'b0; m_ret_valid = 1'b1; m_ret_tag = 3'd4;
    @(negedge clk); m_ret_valid = 1'b0; m_ar_valid = 1'b1; #1;
    chk(m_ar_ready === 1'b1 && m_req_tag === 3'd4, "R8 reuse after retire", int'(m_ar_ready), 1);
    @(negedge clk); m_ar_valid = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule